// File: doc/BRIEF.md
# System Control Register File

This block holds the system-control registers of a 64-bit processor core. An access port selects one of 32 register numbers with a 5-bit field and performs either a 32-bit or a 64-bit read or write. Each register applies its own write rule: full replacement, sign extension, truncation to a narrow field, a merge that preserves a fixed group of low bits, touching only the software interrupt bits, or ignoring the write. Reads are combinational. Writes take effect on the rising clock edge of the access cycle.

A free-running counter runs at twice the rate software sees. A separate compare register arms a timer interrupt. The timer is a two-state machine. In `TM_QUIET`, bit 15 of the cause register is clear. When counting moves the visible count onto the compare value, the transition `quiet_to_pending` enters `TM_PENDING`. In that state bit 15 and the `timer_irq` output are set. The only exit is `pending_to_quiet`, taken when the compare register is written. A compare write in `TM_QUIET` also takes priority over a simultaneous hit.

An open-bus latch captures every accepted write. Register numbers with no storage read back that latch. A 64-bit access to a register that has no 64-bit path is refused through an error flag. A refused access changes nothing.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, a 32-bit read of the cause register (number 13) returns 0xB000007C. Every other register, the open-bus latch and the visible count read zero, and `timer_irq` is low.
- R2: An accepted write stores its data in the open-bus latch, zero-extended if the write is 32-bit. Reads of numbers 7, 21, 22, 23, 24, 25 and 31 return the latch. A write to one of those numbers changes no other register.
- R3: A write to compare (number 11) loads the value. It also clears the timer-pending bit, cause bit 15, on the same edge. `timer_irq` always equals cause bit 15.
- R4: The counter is one bit wider than the visible count (number 9) and advances once per clock. A write to count loads the written value as the visible count. The visible count then advances by one every two clocks.
- R5: Cause bit 15 is set on the edge where counting moves the visible count onto the compare value. It stays set until compare is written. A count write that lands directly on the compare value does not set it.
- R6: A write to cause changes only bits 9:8 (the two software interrupt bits), taken from the same bit positions of the data. All other cause bits keep their values.
- R7: Wired (number 6) keeps only data bits 5:0. Parity-error (number 26) keeps only data bits 7:0.
- R8: Writes to numbers 1, 8, 15 and 27 are ignored, and those registers keep reading zero.
- R9: A write to context (number 4) replaces only bits 63:23 and keeps bits 22:0. A 32-bit write first sign-extends its data from bit 31.
- R10: A write to extended context (number 20) replaces only bits 63:33 and keeps bits 32:0. A 32-bit write first sign-extends its data. A 64-bit read returns the register with bits 3:0 forced to zero.
- R11: 32-bit writes to numbers 10, 14 and 30 sign-extend bit 31 into bits 63:32. 32-bit writes to the other full-width registers zero-extend. A 32-bit read returns bits 31:0 in `rd_data[31:0]`, with the upper half zero.
- R12: A 64-bit read is legal only for numbers 2, 3, 4, 8, 10, 12, 14, 15, 17, 20, 30 and the open-bus numbers. A 64-bit write is legal only for numbers 2, 3, 4, 8, 10, 12, 13, 14, 17, 20 and 30. Any other 64-bit access raises `acc_err`, returns zero data and changes no state, including the open-bus latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_dw | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_num | input | 5 | Register number |
| wr_data | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| rd_data | output | 64 | Read data, combinational, zero when not reading or refused |
| acc_err | output | 1 | 64-bit access to a register with no 64-bit path |
| timer_irq | output | 1 | Timer interrupt pending (cause bit 15) |

## Verification
The assertions assume `acc_en`, `acc_wr`, `acc_dw` and `acc_num` are stable for a whole cycle around each rising edge. They also assume the counter never wraps within the window a property observes. The stimulus meets the first assumption by changing inputs only just after an edge and holding them for a full cycle. It meets the second by keeping all count and compare values far below the 32-bit wrap point. The pending-hold and clear properties also rely on compare writes coming only through the port. The directed timer tests write compare and count only at chosen moments, so each hit and each clear falls on a predictable edge.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW        = 64;
    localparam int NUM_W     = 5;
    localparam int NREG      = 1 << NUM_W;
    localparam int HALF_W    = DW / 2;
    localparam int CTX_KEEP  = 23;
    localparam int XCTX_KEEP = 33;
    localparam int XCTX_CLR  = 4;
    localparam int WIRED_W   = 6;
    localparam int PARITY_W  = 8;
    localparam int IP_SW_LO  = 8;
    localparam int IP_SW_W   = 2;
    localparam int IP_TIMER  = 15;

    localparam logic [DW-1:0] CAUSE_RST = 64'h0000_0000_B000_007C;

    localparam logic [NUM_W-1:0] N_RAND    = 5'd1;
    localparam logic [NUM_W-1:0] N_CTX     = 5'd4;
    localparam logic [NUM_W-1:0] N_WIRED   = 5'd6;
    localparam logic [NUM_W-1:0] N_BADADDR = 5'd8;
    localparam logic [NUM_W-1:0] N_CNT     = 5'd9;
    localparam logic [NUM_W-1:0] N_VHI     = 5'd10;
    localparam logic [NUM_W-1:0] N_CMP     = 5'd11;
    localparam logic [NUM_W-1:0] N_CAUSE   = 5'd13;
    localparam logic [NUM_W-1:0] N_EXC_PC  = 5'd14;
    localparam logic [NUM_W-1:0] N_IDENT   = 5'd15;
    localparam logic [NUM_W-1:0] N_XCTX    = 5'd20;
    localparam logic [NUM_W-1:0] N_PARITY  = 5'd26;
    localparam logic [NUM_W-1:0] N_CACHEER = 5'd27;
    localparam logic [NUM_W-1:0] N_ERR_PC  = 5'd30;

    typedef enum logic [3:0] {
        WR_PLAIN,
        WR_SEXT,
        WR_IGNORE,
        WR_LOW6,
        WR_LOW8,
        WR_CTX,
        WR_XCTX,
        WR_CAUSE,
        WR_COUNT,
        WR_COMPARE,
        WR_OPEN
    } wr_rule_e;

    typedef enum logic {
        TM_QUIET,
        TM_PENDING
    } tm_state_e;

    function automatic logic is_open(input logic [NUM_W-1:0] n);
        case (n)
            5'd7, 5'd21, 5'd22, 5'd23, 5'd24, 5'd25, 5'd31: is_open = 1'b1;
            default:                                          is_open = 1'b0;
        endcase
    endfunction

    function automatic wr_rule_e rule_of(input logic [NUM_W-1:0] n);
        if (is_open(n))
            rule_of = WR_OPEN;
        else begin
            case (n)
                N_RAND, N_BADADDR, N_IDENT, N_CACHEER: rule_of = WR_IGNORE;
                N_CTX:                                 rule_of = WR_CTX;
                N_XCTX:                                rule_of = WR_XCTX;
                N_WIRED:                               rule_of = WR_LOW6;
                N_PARITY:                              rule_of = WR_LOW8;
                N_VHI, N_EXC_PC, N_ERR_PC:             rule_of = WR_SEXT;
                N_CNT:                                 rule_of = WR_COUNT;
                N_CMP:                                 rule_of = WR_COMPARE;
                N_CAUSE:                               rule_of = WR_CAUSE;
                default:                               rule_of = WR_PLAIN;
            endcase
        end
    endfunction

    function automatic logic banked(input logic [NUM_W-1:0] n);
        case (rule_of(n))
            WR_PLAIN, WR_SEXT, WR_LOW6, WR_LOW8, WR_CTX, WR_XCTX: banked = 1'b1;
            default:                                                banked = 1'b0;
        endcase
    endfunction

    function automatic logic rd64_ok(input logic [NUM_W-1:0] n);
        if (is_open(n))
            rd64_ok = 1'b1;
        else begin
            case (n)
                5'd2, 5'd3, 5'd4, 5'd8, 5'd10, 5'd12,
                5'd14, 5'd15, 5'd17, 5'd20, 5'd30: rd64_ok = 1'b1;
                default:                           rd64_ok = 1'b0;
            endcase
        end
    endfunction

    function automatic logic wr64_ok(input logic [NUM_W-1:0] n);
        case (n)
            5'd2, 5'd3, 5'd4, 5'd8, 5'd10, 5'd12,
            5'd13, 5'd14, 5'd17, 5'd20, 5'd30: wr64_ok = 1'b1;
            default:                           wr64_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_merge.sv
module sysctl_merge
    import sysctl_pkg::*;
(
    input  wr_rule_e          rule,
    input  logic              dw,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     old,
    output logic [DW-1:0]     nxt
);

    logic [DW-1:0] src_z;
    logic [DW-1:0] src_s;

    always_comb begin
        src_z = dw ? wdata : {{(DW-HALF_W){1'b0}}, wdata[HALF_W-1:0]};
        src_s = dw ? wdata : {{(DW-HALF_W){wdata[HALF_W-1]}}, wdata[HALF_W-1:0]};
    end

    always_comb begin
        unique case (rule)
            WR_PLAIN: nxt = src_z;
            WR_SEXT:  nxt = src_s;
            WR_LOW6:  nxt = {{(DW-WIRED_W){1'b0}}, wdata[WIRED_W-1:0]};
            WR_LOW8:  nxt = {{(DW-PARITY_W){1'b0}}, wdata[PARITY_W-1:0]};
            WR_CTX:   nxt = {src_s[DW-1:CTX_KEEP], old[CTX_KEEP-1:0]};
            WR_XCTX:  nxt = {src_s[DW-1:XCTX_KEEP], old[XCTX_KEEP-1:0]};
            default:  nxt = old;
        endcase
    end

endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer
    import sysctl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] vis,
    output logic [CNT_W-1:0] cmp_q,
    output logic             ip7
);

    logic [CNT_W:0] cnt_q;
    tm_state_e      state_q;
    tm_state_e      state_d;
    logic           tick;
    logic           hit;

    assign vis  = cnt_q[CNT_W:1];
    assign tick = cnt_q[0] && !cnt_wr;
    assign hit  = tick && (CNT_W'(vis + 1'b1) == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= {wval, 1'b0};
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_wr)
            cmp_q <= wval;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TM_QUIET;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_QUIET:   if (hit && !cmp_wr) state_d = TM_PENDING;
            TM_PENDING: if (cmp_wr)         state_d = TM_QUIET;
            default:                        state_d = TM_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TM_PENDING: ip7 = 1'b1;
            default:    ip7 = 1'b0;
        endcase
    end

    // R3
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !ip7);

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip7 && !cmp_wr) |=> ip7);

    // R5
    rise_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ip7) |-> (vis == cmp_q));

    // R4
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_wr) |-> (vis == $past(vis) || vis == CNT_W'($past(vis) + 1'b1)));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  logic [NUM_W-1:0] num,
    input  logic             dw,
    input  logic [DW-1:0]    bank [NREG],
    input  logic [DW-1:0]    open_q,
    input  logic [DW-1:0]    cnt_view,
    input  logic [DW-1:0]    cmp_view,
    input  logic [DW-1:0]    cause_view,
    output logic [DW-1:0]    val
);

    logic [DW-1:0] raw;

    always_comb begin
        unique case (rule_of(num))
            WR_OPEN:    raw = open_q;
            WR_COUNT:   raw = cnt_view;
            WR_COMPARE: raw = cmp_view;
            WR_CAUSE:   raw = cause_view;
            default:    raw = bank[num];
        endcase
    end

    always_comb begin
        if (dw) begin
            val = raw;
            if (num == N_XCTX)
                val[XCTX_CLR-1:0] = '0;
        end else begin
            val = {{(DW-HALF_W){1'b0}}, raw[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic             acc_dw,
    input  logic [4:0]       acc_num,
    input  logic [63:0]      wr_data,
    output logic [63:0]      rd_data,
    output logic             acc_err,
    output logic             timer_irq
);

    logic [DW-1:0]      bank [NREG];
    logic [DW-1:0]      merged;
    logic [DW-1:0]      open_q;
    logic [DW-1:0]      cause_view;
    logic [DW-1:0]      rd_val;
    logic [IP_SW_W-1:0] ip_sw;
    logic [CNT_W-1:0]   vis;
    logic [CNT_W-1:0]   cmp_q;
    logic               ip7;
    logic               wr_go;
    logic               rd_go;
    wr_rule_e           rule;

    assign rule    = rule_of(acc_num);
    assign acc_err = acc_en && acc_dw &&
                     (acc_wr ? !wr64_ok(acc_num) : !rd64_ok(acc_num));
    assign wr_go   = acc_en && acc_wr && !acc_err;
    assign rd_go   = acc_en && !acc_wr && !acc_err;

    sysctl_merge u_merge (
        .rule  (rule),
        .dw    (acc_dw),
        .wdata (wr_data),
        .old   (bank[acc_num]),
        .nxt   (merged)
    );

    for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
        if (banked(NUM_W'(gi))) begin : g_st
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_go && acc_num == NUM_W'(gi))
                    q <= merged;
            end
            assign bank[gi] = q;
        end else begin : g_nil
            assign bank[gi] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            open_q <= '0;
        else if (wr_go)
            open_q <= acc_dw ? wr_data : {{(DW-HALF_W){1'b0}}, wr_data[HALF_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ip_sw <= '0;
        else if (wr_go && rule == WR_CAUSE)
            ip_sw <= wr_data[IP_SW_LO +: IP_SW_W];
    end

    sysctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_wr (wr_go && rule == WR_COUNT),
        .cmp_wr (wr_go && rule == WR_COMPARE),
        .wval   (wr_data[CNT_W-1:0]),
        .vis    (vis),
        .cmp_q  (cmp_q),
        .ip7    (ip7)
    );

    always_comb begin
        cause_view = CAUSE_RST;
        cause_view[IP_SW_LO +: IP_SW_W] = ip_sw;
        cause_view[IP_TIMER] = ip7;
    end

    sysctl_rdmux u_rdmux (
        .num        (acc_num),
        .dw         (acc_dw),
        .bank       (bank),
        .open_q     (open_q),
        .cnt_view   ({{(DW-CNT_W){1'b0}}, vis}),
        .cmp_view   ({{(DW-CNT_W){1'b0}}, cmp_q}),
        .cause_view (cause_view),
        .val        (rd_val)
    );

    assign rd_data   = rd_go ? rd_val : '0;
    assign timer_irq = ip7;

    // R12
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (rd_data == '0));

    // R12
    err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> $stable(open_q));

    // R2
    open_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !acc_dw && is_open(acc_num)) |-> (rd_data[HALF_W-1:0] == open_q[HALF_W-1:0]));

    // R6
    cause_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && rule == WR_CAUSE) |=> $stable(ip_sw));

    // R7
    wired_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank[N_WIRED][DW-1:WIRED_W] == '0);

endmodule

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_dw = 1'b0;
    logic [4:0]  acc_num = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        acc_err;
    logic        timer_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sysctl_regfile u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_dw    (acc_dw),
        .acc_num   (acc_num),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .acc_err   (acc_err),
        .timer_irq (timer_irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit dw, input logic [4:0] n, input logic [63:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_dw = dw; acc_num = n; wr_data = d;
        @(posedge clk);
        #1;
        acc_en = 1'b0; acc_wr = 1'b0; acc_dw = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input bit dw, input logic [4:0] n, output logic [63:0] d, output logic e);
        acc_en = 1'b1; acc_wr = 1'b0; acc_dw = dw; acc_num = n;
        #2;
        d = rd_data;
        e = acc_err;
        #1;
        acc_en = 1'b0; acc_dw = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] d; logic e;
        rd(0, 5'd13, d, e); chk("R1 cause reset", d, 64'hB000_007C);
        rd(0, 5'd6,  d, e); chk("R1 wired reset", d, 0);
        rd(1, 5'd14, d, e); chk("R1 exc pc reset", d, 0);
        rd(1, 5'd7,  d, e); chk("R1 open latch reset", d, 0);
        rd(0, 5'd9,  d, e); chk("R1 count reset", d, 0);
        rd(0, 5'd11, d, e); chk("R1 compare reset", d, 0);
        chk("R1 irq reset", {63'd0, timer_irq}, 0);
    endtask

    task automatic t_cause();
        logic [63:0] d; logic e;
        wr(0, 5'd13, 64'hFFFF_FFFF);
        rd(0, 5'd13, d, e); chk("R6 cause sw bits set", d, 64'hB000_037C);
        wr(1, 5'd13, 64'h0000_0000_0000_0100);
        rd(0, 5'd13, d, e); chk("R6 cause 64-bit write", d, 64'hB000_017C);
        wr(0, 5'd13, 64'h0);
        rd(0, 5'd13, d, e); chk("R6 cause sw bits clear", d, 64'hB000_007C);
    endtask

    task automatic t_narrow();
        logic [63:0] d; logic e;
        wr(0, 5'd6, 64'hFFFF_FFC5);
        rd(0, 5'd6, d, e); chk("R7 wired low 6", d, 64'h05);
        wr(0, 5'd26, 64'h1234_5678);
        rd(0, 5'd26, d, e); chk("R7 parity low 8", d, 64'h78);
    endtask

    task automatic t_ignore();
        logic [63:0] d; logic e;
        wr(0, 5'd1,  64'hDEAD_BEEF); rd(0, 5'd1,  d, e); chk("R8 random ignores", d, 0);
        wr(0, 5'd8,  64'hDEAD_BEEF); rd(0, 5'd8,  d, e); chk("R8 badaddr ignores", d, 0);
        wr(1, 5'd8,  64'h1111_2222_3333_4444); rd(1, 5'd8, d, e); chk("R8 badaddr ignores 64", d, 0);
        wr(0, 5'd15, 64'hDEAD_BEEF); rd(0, 5'd15, d, e); chk("R8 ident ignores", d, 0);
        wr(0, 5'd27, 64'hDEAD_BEEF); rd(0, 5'd27, d, e); chk("R8 cache err ignores", d, 0);
    endtask

    task automatic t_ctx();
        logic [63:0] d; logic e;
        wr(1, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(1, 5'd4, d, e); chk("R9 context 64 keeps low", d, 64'hFFFF_FFFF_FF80_0000);
        wr(0, 5'd4, 64'h8000_1234);
        rd(1, 5'd4, d, e); chk("R9 context 32 sext", d, 64'hFFFF_FFFF_8000_0000);
        wr(0, 5'd4, 64'h0123_4567);
        rd(1, 5'd4, d, e); chk("R9 context 32 positive", d, 64'h0000_0000_0100_0000);
        wr(1, 5'd20, 64'hAAAA_AAAA_AAAA_AAAA);
        rd(1, 5'd20, d, e); chk("R10 xcontext 64", d, 64'hAAAA_AAAA_0000_0000);
        wr(0, 5'd20, 64'h8000_0000);
        rd(1, 5'd20, d, e); chk("R10 xcontext 32 sext", d, 64'hFFFF_FFFE_0000_0000);
    endtask

    task automatic t_ext();
        logic [63:0] d; logic e;
        wr(0, 5'd14, 64'h8765_4321);
        rd(1, 5'd14, d, e); chk("R11 exc pc sext", d, 64'hFFFF_FFFF_8765_4321);
        wr(0, 5'd30, 64'h1234_5678);
        rd(1, 5'd30, d, e); chk("R11 err pc positive", d, 64'h0000_0000_1234_5678);
        wr(0, 5'd10, 64'hF000_0000);
        rd(1, 5'd10, d, e); chk("R11 vhi sext", d, 64'hFFFF_FFFF_F000_0000);
        wr(1, 5'd12, 64'h1111_2222_3333_4444);
        wr(0, 5'd12, 64'h8000_0001);
        rd(1, 5'd12, d, e); chk("R11 plain zero-extend", d, 64'h0000_0000_8000_0001);
        wr(1, 5'd17, 64'hCAFE_F00D_1234_5678);
        rd(0, 5'd17, d, e); chk("R11 32-bit read low half", d, 64'h0000_0000_1234_5678);
    endtask

    task automatic t_open();
        logic [63:0] d; logic e;
        logic [63:0] pc_before;
        rd(1, 5'd14, pc_before, e);
        wr(0, 5'd7, 64'h5555_AAAA);
        rd(0, 5'd21, d, e); chk("R2 open read 21", d, 64'h5555_AAAA);
        rd(1, 5'd31, d, e); chk("R2 open read 31 64-bit", d, 64'h5555_AAAA);
        rd(1, 5'd14, d, e); chk("R2 open write no side effect", d, pc_before);
        rd(0, 5'd13, d, e); chk("R2 open write cause untouched", d, 64'hB000_007C);
        wr(1, 5'd14, 64'h0102_0304_0506_0708);
        rd(1, 5'd25, d, e); chk("R2 latch tracks 64-bit write", d, 64'h0102_0304_0506_0708);
    endtask

    task automatic t_err();
        logic [63:0] d; logic e;
        wr(0, 5'd29, 64'h77);
        wr(0, 5'd7, 64'h99);
        rd(1, 5'd6, d, e);
        chk("R12 64-bit read wired err", {63'd0, e}, 1);
        chk("R12 refused read data zero", d, 0);
        wr(1, 5'd29, 64'hFFFF_0000_FFFF_0000);
        rd(0, 5'd29, d, e); chk("R12 refused write no store", d, 64'h77);
        rd(0, 5'd7,  d, e); chk("R12 refused write latch kept", d, 64'h99);
        wr(1, 5'd7, 64'h1234);
        rd(0, 5'd7,  d, e); chk("R12 64-bit write to open refused", d, 64'h99);
        rd(1, 5'd20, d, e); chk("R12 64-bit read xcontext legal", {63'd0, e}, 0);
    endtask

    task automatic t_half_rate();
        logic [63:0] d; logic e;
        wr(0, 5'd9, 64'd1000);
        rd(0, 5'd9, d, e); chk("R4 count load", d, 64'd1000);
        repeat (2) @(posedge clk);
        #1;
        rd(0, 5'd9, d, e); chk("R4 count after two clocks", d, 64'd1001);
        repeat (2) @(posedge clk);
        #1;
        rd(0, 5'd9, d, e); chk("R4 count after four clocks", d, 64'd1002);
    endtask

    task automatic t_timer();
        logic [63:0] d; logic e;
        bit seen99 = 0;
        bit seen100 = 0;
        wr(0, 5'd11, 64'd100);
        rd(0, 5'd11, d, e); chk("R3 compare load", d, 64'd100);
        wr(0, 5'd9, 64'd97);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            #1;
            rd(0, 5'd9, d, e);
            if (d == 64'd99 && !seen99) begin
                seen99 = 1;
                chk("R5 irq low before match", {63'd0, timer_irq}, 0);
            end
            if (d == 64'd100 && !seen100) begin
                seen100 = 1;
                chk("R5 irq set at match", {63'd0, timer_irq}, 1);
                rd(0, 5'd13, d, e); chk("R3 cause bit 15 at match", d, 64'hB000_807C);
            end
        end
        chk("R5 match observed", {63'd0, seen100}, 1);
        chk("R5 irq held past match", {63'd0, timer_irq}, 1);
        wr(0, 5'd13, 64'h0);
        chk("R6 cause write keeps irq", {63'd0, timer_irq}, 1);
        wr(0, 5'd11, 64'd5000);
        chk("R3 compare write clears irq", {63'd0, timer_irq}, 0);
        wr(0, 5'd11, 64'd3000);
        wr(0, 5'd9, 64'd3000);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            chk("R5 count write onto compare no irq", {63'd0, timer_irq}, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_cause();
        t_narrow();
        t_ignore();
        t_ctx();
        t_ext();
        t_open();
        t_err();
        t_half_rate();
        t_timer();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule